// File: doc/BRIEF.md
# Oldest-First Ready Instruction Selector

This block sits beside a circular instruction queue and picks, every clock, up to a fixed number of queue entries that may be sent to functional units. For each entry the queue supplies status bits: two source-operand locks, a dispatched flag, an executed flag, a store flag and a functional-unit type code. It also supplies the head and tail pointers, and there is one busy input per functional-unit type. An entry is a candidate only if it lies between the tail (the oldest entry) and the head (the next slot to be allocated), counting wraparound.

The selector gives priority by age. Age is the distance from the moving tail, not the raw index. To do this it rotates the ready vector so the oldest entry sits at position zero, runs a chain of find-first pickers, and rotates the picked set back. Each picker masks off every entry that shares a functional-unit type with an earlier pick, so no type gets two grants in one cycle. A store is eligible only while it is the oldest entry.

The results are registered. Each selection slot gives a grant flag and an entry index, and a mask over all entries marks the granted entries so that the queue can set their dispatched flags.

Top module: `ready_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output becomes zero after that edge.
- R2: An entry whose `src1_lock`, `src2_lock`, `dispatched` or `executed` bit is set is never granted.
- R3: An entry whose functional-unit type `t` has `fu_busy[t]` set is never granted. Entry `i` has its 2-bit type code at `fu_type[2i+1:2i]`.
- R4: Pointers carry one wrap bit above the 3-bit index. The candidate window is the entries whose age `(i - tail[2:0]) mod 8` is below the occupancy `(head - tail) mod 16`. Equal pointers mean an empty queue with no grants. Equal index bits with different wrap bits mean a full queue.
- R5: Grants go to eligible entries in increasing age. Slot 0 holds the oldest granted entry and slot 1 the next oldest.
- R6: At most one entry of each functional-unit type is granted in a cycle. An entry that loses only because of this rule lets the next older-first eligible entry of another type take the slot.
- R7: An entry with its `is_store` bit set is granted only when its age is 0, that is, it is the entry at the tail.
- R8: `set_disp` has exactly the bits of the granted entries set. Slots fill from slot 0 upward. An unused slot shows `grant_vld` low and index 0.
- R9: Outputs change only at a rising clock edge. They reflect the inputs present just before that edge and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_ptr | input | 4 | Next allocation slot, with wrap bit in the MSB |
| tail_ptr | input | 4 | Oldest entry, with wrap bit in the MSB |
| src1_lock | input | 8 | Per-entry first source operand pending |
| src2_lock | input | 8 | Per-entry second source operand pending |
| dispatched | input | 8 | Per-entry already sent to a unit |
| executed | input | 8 | Per-entry result already produced |
| is_store | input | 8 | Per-entry store flag |
| fu_type | input | 16 | Per-entry 2-bit functional-unit type, entry i at bits 2i+1:2i |
| fu_busy | input | 4 | Per-type busy flag |
| grant_vld | output | 2 | Per-slot grant |
| grant_idx | output | 6 | Per-slot entry index, slot k at bits 3k+2:3k |
| set_disp | output | 8 | Mask of granted entries, used to set their dispatched flags |

## Verification
All three outputs come from one register stage, so the grants for a set of inputs are due exactly one rising edge after those inputs are applied. The bench changes inputs 1 ns after a rising edge. It then confirms that the outputs still show the previous expectation, since nothing may move before the edge. After the next edge it compares them, again 1 ns later, with a model computed from the requirements. Directed cases cover reset, an empty and a full queue, wraparound, locks, busy types, a type conflict and the two store positions. Seeded random patterns cover the rest.

// File: rtl/sel_pkg.sv
// Package: default sizes shared by the ready-selector modules.
// Assumes the entry count is a power of two so that index arithmetic wraps.
package sel_pkg;
    parameter int DEF_ENTRIES = 8;
    parameter int DEF_FU_TYPES = 4;
    parameter int DEF_SLOTS = 2;
endpackage

// File: rtl/sel_rotate.sv
// Module: sel_rotate
// Rotates a vector by a variable amount, either right (toward bit 0) or left.
// Assumes amt < W.
module sel_rotate #(
    parameter int W = 8,
    parameter int SH_W = 3,
    parameter bit LEFT = 1'b0
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [2*W-1:0] shd;

    generate
        if (LEFT) begin : g_left
            // purpose: upper half of the doubled word shifted left is the left rotation
            assign shd  = {din, din} << amt;
            assign dout = shd[2*W-1:W];
        end else begin : g_right
            // purpose: lower half of the doubled word shifted right is the right rotation
            assign shd  = {din, din} >> amt;
            assign dout = shd[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sel_prio_pick.sv
// Module: sel_prio_pick
// Find-first picker: reports the lowest set bit of req as an index and a one-hot.
// Assumes IW is wide enough to hold W-1.
module sel_prio_pick #(
    parameter int W = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] pos,
    output logic [W-1:0]  onehot
);
    // purpose: scan from the top so the lowest requesting position wins
    always_comb begin
        found = |req;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) pos = IW'(i);
        end
        onehot = found ? (W'(1) << pos) : '0;
    end
endmodule

// File: rtl/sel_eligibility.sv
// Module: sel_eligibility
// Works out, per entry in physical index order, whether the entry may be picked.
// The entry must be inside the tail..head window and have both locks clear. It
// must be neither dispatched nor executed, and its unit type must not be busy.
// A store must also sit at the tail. Pointers carry one wrap bit above the index.
module sel_eligibility #(
    parameter int NUM_ENT = 8,
    parameter int NUM_FU = 4,
    parameter int IDX_W = 3,
    parameter int FU_W = 2
) (
    input  logic [IDX_W:0]          head_ptr,
    input  logic [IDX_W:0]          tail_ptr,
    input  logic [NUM_ENT-1:0]      src1_lock,
    input  logic [NUM_ENT-1:0]      src2_lock,
    input  logic [NUM_ENT-1:0]      dispatched,
    input  logic [NUM_ENT-1:0]      executed,
    input  logic [NUM_ENT-1:0]      is_store,
    input  logic [NUM_ENT*FU_W-1:0] fu_type,
    input  logic [NUM_FU-1:0]       fu_busy,
    output logic [NUM_ENT-1:0]      ready
);
    logic [IDX_W:0] occupancy;

    // purpose: number of live entries from tail up to head
    assign occupancy = head_ptr - tail_ptr;

    // purpose: per-entry eligibility from window, status bits, unit busy and store rule
    always_comb begin
        logic [IDX_W-1:0] age;
        logic [FU_W-1:0]  typ;
        logic             in_win;
        logic             unit_free;
        logic             store_ok;
        for (int i = 0; i < NUM_ENT; i++) begin
            age       = IDX_W'(i) - tail_ptr[IDX_W-1:0];
            in_win    = {1'b0, age} < occupancy;
            typ       = fu_type[i*FU_W +: FU_W];
            unit_free = !fu_busy[typ];
            store_ok  = !is_store[i] || (age == '0);
            ready[i]  = in_win && !src1_lock[i] && !src2_lock[i] && !dispatched[i]
                        && !executed[i] && unit_free && store_ok;
        end
    end
endmodule

// File: rtl/ready_select.sv
// Module: ready_select
// Picks up to NUM_SEL eligible queue entries per cycle, oldest first by distance
// from the tail. No functional-unit type gets more than one grant per cycle.
// The ready vector is rotated so the oldest entry is at bit 0, a chain of
// find-first pickers each drop the type of the previous pick, and the picked
// one-hots are rotated back. Outputs are registered (one-cycle latency).
// Assumes NUM_ENT is a power of two and NUM_FU is a power of two.
module ready_select #(
    parameter int NUM_ENT = sel_pkg::DEF_ENTRIES,
    parameter int NUM_FU = sel_pkg::DEF_FU_TYPES,
    parameter int NUM_SEL = sel_pkg::DEF_SLOTS,
    localparam int IDX_W = $clog2(NUM_ENT),
    localparam int PTR_W = IDX_W + 1,
    localparam int FU_W = $clog2(NUM_FU)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PTR_W-1:0]         head_ptr,
    input  logic [PTR_W-1:0]         tail_ptr,
    input  logic [NUM_ENT-1:0]       src1_lock,
    input  logic [NUM_ENT-1:0]       src2_lock,
    input  logic [NUM_ENT-1:0]       dispatched,
    input  logic [NUM_ENT-1:0]       executed,
    input  logic [NUM_ENT-1:0]       is_store,
    input  logic [NUM_ENT*FU_W-1:0]  fu_type,
    input  logic [NUM_FU-1:0]        fu_busy,
    output logic [NUM_SEL-1:0]       grant_vld,
    output logic [NUM_SEL*IDX_W-1:0] grant_idx,
    output logic [NUM_ENT-1:0]       set_disp
);
    logic [IDX_W-1:0]   tail_idx;
    logic [NUM_ENT-1:0] ready_phys;
    logic [NUM_ENT-1:0] ready_rot;
    logic [FU_W-1:0]    rot_type [NUM_ENT];
    logic [NUM_ENT-1:0] cand [NUM_SEL+1];
    logic               found_w [NUM_SEL];
    logic [IDX_W-1:0]   pos_r [NUM_SEL];
    logic [NUM_ENT-1:0] oh_r [NUM_SEL];
    logic [IDX_W-1:0]   phys_idx [NUM_SEL];
    logic [NUM_ENT-1:0] pick_rot;
    logic [NUM_ENT-1:0] pick_phys;

    assign tail_idx = tail_ptr[IDX_W-1:0];

    sel_eligibility #(
        .NUM_ENT(NUM_ENT), .NUM_FU(NUM_FU), .IDX_W(IDX_W), .FU_W(FU_W)
    ) u_elig (
        .head_ptr(head_ptr), .tail_ptr(tail_ptr),
        .src1_lock(src1_lock), .src2_lock(src2_lock),
        .dispatched(dispatched), .executed(executed), .is_store(is_store),
        .fu_type(fu_type), .fu_busy(fu_busy), .ready(ready_phys)
    );

    sel_rotate #(.W(NUM_ENT), .SH_W(IDX_W), .LEFT(1'b0)) u_rot_in (
        .din(ready_phys), .amt(tail_idx), .dout(ready_rot)
    );

    // purpose: unit type of each entry, listed in age order
    always_comb begin
        logic [IDX_W-1:0] ent;
        for (int p = 0; p < NUM_ENT; p++) begin
            ent         = IDX_W'(p) + tail_idx;
            rot_type[p] = fu_type[ent*FU_W +: FU_W];
        end
    end

    assign cand[0] = ready_rot;

    generate
        for (genvar k = 0; k < NUM_SEL; k++) begin : g_slot
            logic [NUM_ENT-1:0] same_type;

            sel_prio_pick #(.W(NUM_ENT), .IW(IDX_W)) u_pick (
                .req(cand[k]), .found(found_w[k]), .pos(pos_r[k]), .onehot(oh_r[k])
            );

            // purpose: mark every entry sharing the unit type just picked
            always_comb begin
                for (int p = 0; p < NUM_ENT; p++) begin
                    same_type[p] = (rot_type[p] == rot_type[pos_r[k]]);
                end
            end

            assign cand[k+1]   = cand[k] & ~(found_w[k] ? same_type : '0);
            assign phys_idx[k] = pos_r[k] + tail_idx;
        end
    endgenerate

    // purpose: merge the per-slot picks in age order
    always_comb begin
        pick_rot = '0;
        for (int k = 0; k < NUM_SEL; k++) pick_rot = pick_rot | oh_r[k];
    end

    sel_rotate #(.W(NUM_ENT), .SH_W(IDX_W), .LEFT(1'b1)) u_rot_out (
        .din(pick_rot), .amt(tail_idx), .dout(pick_phys)
    );

    // purpose: register grants, indices and the dispatched-set mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= '0;
            grant_idx <= '0;
            set_disp  <= '0;
        end else begin
            for (int k = 0; k < NUM_SEL; k++) begin
                grant_vld[k]                  <= found_w[k];
                grant_idx[k*IDX_W +: IDX_W]   <= found_w[k] ? phys_idx[k] : '0;
            end
            set_disp <= pick_phys;
        end
    end

    // ---------------- assertions ----------------
    logic armed;

    // purpose: enable checks only once a full cycle of history follows reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic [FU_W-1:0] type_of(input logic [NUM_ENT*FU_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
        return t[i*FU_W +: FU_W];
    endfunction

    function automatic logic busy_hit(input logic [NUM_FU-1:0] b,
                                      input logic [NUM_ENT*FU_W-1:0] t,
                                      input logic [IDX_W-1:0] i);
        return b[type_of(t, i)];
    endfunction

    logic [IDX_W-1:0] out_idx [NUM_SEL];

    assert_no_blocked_grant_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (set_disp & $past(src1_lock | src2_lock | dispatched | executed)) == '0)
        else $error("blocked entry granted");

    assert_empty_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(head_ptr == tail_ptr) |-> (set_disp == '0))
        else $error("grant from empty queue");

    assert_store_at_tail_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (set_disp & $past(is_store) & ~(NUM_ENT'(1) << $past(tail_idx))) == '0)
        else $error("store granted while not oldest");

    assert_mask_count_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $countones(set_disp) == $countones(grant_vld))
        else $error("mask and grants disagree");

    generate
        for (genvar k = 0; k < NUM_SEL; k++) begin : g_chk
            assign out_idx[k] = grant_idx[k*IDX_W +: IDX_W];

            assert_busy_unit_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                grant_vld[k] |-> !busy_hit($past(fu_busy), $past(fu_type), out_idx[k]))
                else $error("grant to busy unit type");

            assert_mask_has_slot_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                grant_vld[k] |-> set_disp[out_idx[k]])
                else $error("granted index missing from mask");

            if (k > 0) begin : g_order
                assert_age_order_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                    grant_vld[k] |-> (grant_vld[k-1] &&
                        (IDX_W'(out_idx[k] - $past(tail_idx)) >
                         IDX_W'(out_idx[k-1] - $past(tail_idx)))))
                    else $error("slots out of age order");
            end

            for (genvar j = 0; j < k; j++) begin : g_pair
                assert_one_per_type_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                    (grant_vld[j] && grant_vld[k]) |->
                        (type_of($past(fu_type), out_idx[j]) != type_of($past(fu_type), out_idx[k])))
                    else $error("two grants of one unit type");
            end
        end
    endgenerate
endmodule

// File: tb/sim_ready_select.sv
module sim_ready_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  head_ptr = '0, tail_ptr = '0;
    logic [7:0]  src1_lock = '0, src2_lock = '0, dispatched = '0, executed = '0, is_store = '0;
    logic [15:0] fu_type = '0;
    logic [3:0]  fu_busy = '0;
    logic [1:0]  grant_vld;
    logic [5:0]  grant_idx;
    logic [7:0]  set_disp;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] exp_vld, prev_vld;
    logic [5:0] exp_idx, prev_idx;
    logic [7:0] exp_mask, prev_mask;

    always #5 clk = ~clk;

    ready_select u0 (
        .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
        .src1_lock(src1_lock), .src2_lock(src2_lock), .dispatched(dispatched),
        .executed(executed), .is_store(is_store), .fu_type(fu_type),
        .fu_busy(fu_busy), .grant_vld(grant_vld), .grant_idx(grant_idx), .set_disp(set_disp)
    );

    // Expected outputs from the requirements: walk ages from the tail (R4, R5),
    // apply status and busy (R2, R3), store rule (R7), one per type (R6).
    function automatic void model(output logic [1:0] v, output logic [5:0] ix, output logic [7:0] m);
        logic [3:0] occ;
        logic [3:0] used;
        int cnt;
        occ = head_ptr - tail_ptr;
        used = '0; cnt = 0; v = '0; ix = '0; m = '0;
        for (int o = 0; o < 8; o++) begin
            int e;
            int t;
            e = (int'(tail_ptr[2:0]) + o) % 8;
            t = int'(fu_type[e*2 +: 2]);
            if (o < int'(occ) && !src1_lock[e] && !src2_lock[e] && !dispatched[e] &&
                !executed[e] && !fu_busy[t] && (!is_store[e] || o == 0) && !used[t] && cnt < 2) begin
                v[cnt] = 1'b1;
                ix[cnt*3 +: 3] = 3'(e);
                m[e] = 1'b1;
                used[t] = 1'b1;
                cnt++;
            end
        end
    endfunction

    task automatic compare(input string tag, input logic [1:0] v, input logic [5:0] ix, input logic [7:0] m);
        n_chk++;
        if (grant_vld !== v || grant_idx !== ix || set_disp !== m) begin
            n_fail++;
            $display("FAIL %s: got vld=%b idx=%h mask=%b, expected vld=%b idx=%h mask=%b",
                     tag, grant_vld, grant_idx, set_disp, v, ix, m);
        end
    endtask

    // Inputs were set just after a rising edge; outputs must not move until the next edge.
    task automatic step(input string tag);
        model(exp_vld, exp_idx, exp_mask);
        #2;
        compare("R9 hold before edge", prev_vld, prev_idx, prev_mask);
        @(posedge clk);
        #1;
        compare(tag, exp_vld, exp_idx, exp_mask);
        prev_vld = exp_vld; prev_idx = exp_idx; prev_mask = exp_mask;
    endtask

    task automatic all_clear();
        src1_lock = '0; src2_lock = '0; dispatched = '0; executed = '0;
        is_store = '0; fu_busy = '0; fu_type = 16'hE4E4;  // entry i has type i mod 4
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset overrides ready entries
        all_clear(); head_ptr = 4'd4; tail_ptr = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", 2'b00, 6'h0, 8'h00);
        prev_vld = '0; prev_idx = '0; prev_mask = '0;
        rst_n = 1'b1;

        // R4: empty queue, all else ready -> nothing
        all_clear(); head_ptr = 4'd3; tail_ptr = 4'd3;
        step("R4 empty queue");
        // R4 R5: full queue with wrap, tail 5 -> grants 5 then 6
        head_ptr = 4'b1101; tail_ptr = 4'b0101;
        step("R4 R5 full queue wrap");
        // R4: window of two wrapping past the end: tail 7, head 9 -> 7 and 0
        head_ptr = 4'b1001; tail_ptr = 4'b0111;
        step("R4 wrap window");
        // R2: oldest locked/dispatched/executed entries skipped
        all_clear(); head_ptr = 4'd8; tail_ptr = 4'd0;
        src1_lock = 8'b0000_0001; src2_lock = 8'b0000_0010; dispatched = 8'b0000_0100;
        executed = 8'b0000_1000;
        step("R2 status blocks");
        // R3: busy type 0 and 1 -> entries 2,3 chosen
        all_clear(); head_ptr = 4'd8; tail_ptr = 4'd0; fu_busy = 4'b0011;
        step("R3 busy units");
        // R6: all entries same type -> single grant
        all_clear(); fu_type = 16'h0000; head_ptr = 4'd8; tail_ptr = 4'd0;
        step("R6 single type");
        // R6: types 0,0,1 -> slot 1 skips to third entry
        all_clear(); fu_type = 16'hFF10; head_ptr = 4'd4; tail_ptr = 4'd0;
        step("R6 type skip");
        // R7: store at the tail granted
        all_clear(); head_ptr = 4'd6; tail_ptr = 4'd2; is_store = 8'b0000_0100;
        step("R7 store oldest");
        // R7: store one behind a locked oldest is held back
        is_store = 8'b0000_1000; src1_lock = 8'b0000_0100;
        step("R7 store not oldest");
        // R8: no eligible entry leaves slots at zero
        all_clear(); head_ptr = 4'd2; tail_ptr = 4'd0; executed = 8'hFF;
        step("R8 no grant");

        for (int n = 0; n < 400; n++) begin
            head_ptr   = 4'($urandom);
            tail_ptr   = (n % 5 == 0) ? head_ptr : 4'($urandom);
            src1_lock  = 8'($urandom & $urandom);
            src2_lock  = 8'($urandom & $urandom);
            dispatched = 8'($urandom & $urandom & $urandom);
            executed   = 8'($urandom & $urandom & $urandom);
            is_store   = 8'($urandom & $urandom);
            fu_type    = 16'($urandom);
            fu_busy    = 4'($urandom & $urandom);
            step("R2 R3 R5 R6 R7 R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule